// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a receive chain and puts decoded transport packets onto an output port. That port is either one byte wide or one bit wide. Packets come in as a byte stream with a valid/ready handshake. The first byte of each packet is marked, and that first byte also carries an error marker and a parity-length select. A packet always holds 188 data bytes. In redundancy mode the upstream logic sends the 16 or 20 parity bytes straight after them. The block produces an output clock by toggling an internal phase every `HALF_DIV` core cycles. Along with the data it drives a packet-start strobe, a packet-valid framing signal and an error flag. The polarity of the clock and of each of the three strobes can be set on its own.

Output data and strobes change on the inactive edge of the output clock, so a receiver samples them on the active edge. The serial/parallel choice, the redundancy choice and the parity length are taken from the first byte of each packet. A mode change therefore waits for the next packet. Bytes that arrive outside a packet without a start marker are accepted and thrown away.

Back-pressure rules: a byte is transferred in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the one-byte holding stage is empty, or whenever it is handing its byte to the output in that cycle. While `in_ready` is low, upstream keeps its byte and its markers steady. Upstream may drop `in_valid` between any two bytes. If the holding stage is empty when the next byte is due, the port shows idle slots.

Top module: `ts_out_fmt`

## Requirements
- R1: An input byte is taken only in a cycle where `in_valid` and `in_ready` are both high. A byte in the holding stage stays unchanged until the output takes it. No byte is lost or duplicated.
- R2: In serial mode (`cfg_serial`=1 at the first byte), each output clock period carries one bit.
  - The bit is on `ts_data[7]`, and each byte goes out most significant bit first.
  - `ts_data[6:0]` are 0.
- R3: In parallel mode, each output clock period carries one whole byte on `ts_data`, exactly as received. Bit 7 is the first bit of the stream.
- R4: The start strobe is active only during the first byte of a packet. In serial mode it is active for all 8 bit periods of that byte.
- R5: In data-only mode (`cfg_redund`=0), the packet-valid signal is active in every slot, including idle slots.
- R6: In redundancy mode (`cfg_redund`=1), the 188 data bytes go out with packet-valid active. The parity bytes follow with packet-valid inactive: 16 of them when `in_par20`=0 and 20 when `in_par20`=1. Idle slots show packet-valid inactive.
- R7: If `in_err` is 1 on the first byte of a packet, the error flag is active for every byte of that packet, parity included. Otherwise it is inactive.
- R8: Each of `ts_clk`, `ts_start`, `ts_valid` and `ts_err` is inverted when its polarity input is 1. With `pol_clk`=0 the rising edge is the active edge.
- R9: Output data and strobes change only on the inactive output clock edge. They stay constant for the whole active half period.
- R10: Serial mode, redundancy mode and parity length are captured from the first byte of a packet. Changing them during a packet has no effect on that packet.
- R11: Outside a packet, a byte without `in_sop` is accepted and discarded. Inside a packet, `in_sop`, and the `in_err` that comes with it, are ignored.
- R12: Right after reset, the outputs are in this state:
  - `ts_data`=0.
  - The start and error strobes are inactive and packet-valid is active.
  - `ts_clk` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_err | input | 1 | Packet known to be in error (read with the first byte) |
| in_par20 | input | 1 | Parity length 20 (1) or 16 (0), read with the first byte |
| cfg_serial | input | 1 | 1 = bit-serial port, 0 = byte-parallel port |
| cfg_redund | input | 1 | 1 = data plus parity, 0 = data only |
| pol_clk | input | 1 | Invert output clock |
| pol_start | input | 1 | Invert start strobe |
| pol_valid | input | 1 | Invert packet-valid |
| pol_err | input | 1 | Invert error flag |
| ts_clk | output | 1 | Output clock |
| ts_data | output | 8 | Output data (serial data on bit 7) |
| ts_start | output | 1 | Packet-start strobe |
| ts_valid | output | 1 | Packet-valid framing |
| ts_err | output | 1 | Error flag |

## Verification
The bench builds the block with its default parameters:
- 188 data bytes;
- parity lengths of 16 and 20;
- a half period of two core cycles.

With these values, complete parallel and serial packets of both parity lengths run in a few thousand cycles each. Mode switches between packets, mid-packet mode changes and stray start markers can therefore all be exercised on full-length packets. Because one byte takes four core cycles even in parallel mode, the short half period also makes back-pressure happen naturally. The holding stage is therefore exercised without any gaps being forced upstream.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;
  // One byte on its way to the output port, with its per-packet attributes.
  typedef struct packed {
    logic [7:0] data;
    logic       start;    // first byte of packet
    logic       is_data;  // data byte (not parity)
    logic       err;      // packet flagged in error
    logic       serial;   // packet goes out bit-serial
    logic       redund;   // packet carries parity
  } ts_slot_t;
endpackage

// File: rtl/ts_fmt_clkgen.sv
module ts_fmt_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic launch
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap   = (cnt == LAST);
  // launch: internal clock is about to fall (inactive edge)
  assign launch = wrap & phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R9: each launch leaves the internal clock low
  p_launch_falls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !phase);
endmodule

// File: rtl/ts_fmt_framer.sv
module ts_fmt_framer
  import ts_fmt_pkg::*;
#(
  parameter int DATA_LEN  = 188,
  parameter int PAR_SHORT = 16,
  parameter int PAR_LONG  = 20
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  logic [7:0] in_data,
  input  logic     in_sop,
  input  logic     in_err,
  input  logic     in_par20,
  input  logic     cfg_serial,
  input  logic     cfg_redund,
  input  logic     take,
  output logic     hold_v,
  output ts_slot_t hold
);
  localparam int PW = $clog2(DATA_LEN + PAR_LONG + 1);
  localparam logic [PW-1:0] LAST_PLAIN = PW'(DATA_LEN - 1);
  localparam logic [PW-1:0] LAST_SHORT = PW'(DATA_LEN + PAR_SHORT - 1);
  localparam logic [PW-1:0] LAST_LONG  = PW'(DATA_LEN + PAR_LONG - 1);
  localparam logic [PW-1:0] DATA_END   = PW'(DATA_LEN);

  logic          in_pkt, m_err, m_ser, m_red;
  logic [PW-1:0] pos, last_r, last_c;
  logic          acc, starting, keep;
  ts_slot_t      nxt;

  assign in_ready = ~hold_v | take;
  assign acc      = in_valid & in_ready;
  assign starting = acc & ~in_pkt & in_sop;
  assign keep     = acc & (in_pkt | in_sop);

  always_comb begin
    if (!cfg_redund)    last_c = LAST_PLAIN;
    else if (in_par20)  last_c = LAST_LONG;
    else                last_c = LAST_SHORT;
  end

  always_comb begin
    nxt.data = in_data;
    if (starting) begin
      nxt.start   = 1'b1;
      nxt.is_data = 1'b1;
      nxt.err     = in_err;
      nxt.serial  = cfg_serial;
      nxt.redund  = cfg_redund;
    end else begin
      nxt.start   = 1'b0;
      nxt.is_data = (pos < DATA_END);
      nxt.err     = m_err;
      nxt.serial  = m_ser;
      nxt.redund  = m_red;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold   <= '0;
    end else if (keep) begin
      hold_v <= 1'b1;
      hold   <= nxt;
    end else if (take) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      pos    <= '0;
      last_r <= '0;
      m_err  <= 1'b0;
      m_ser  <= 1'b0;
      m_red  <= 1'b0;
    end else if (starting) begin
      in_pkt <= 1'b1;
      pos    <= PW'(1);
      last_r <= last_c;
      m_err  <= in_err;
      m_ser  <= cfg_serial;
      m_red  <= cfg_redund;
    end else if (acc && in_pkt) begin
      pos <= pos + 1'b1;
      if (pos == last_r) in_pkt <= 1'b0;
    end
  end

  // R1: a waiting byte is never overwritten or dropped
  p_hold_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !take) |=> (hold_v && $stable(hold)));
  // R6: a packet closes exactly at its captured length
  p_pkt_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_pkt) |-> ($past(pos) == $past(last_r)));
endmodule

// File: rtl/ts_fmt_shifter.sv
module ts_fmt_shifter
  import ts_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       cfg_redund,
  input  logic       hold_v,
  input  ts_slot_t   hold,
  output logic       take,
  output logic [7:0] o_data,
  output logic       o_start,
  output logic       o_valid,
  output logic       o_err
);
  ts_slot_t   cur;
  logic       active;
  logic [2:0] bitcnt;
  logic       more_bits;

  assign more_bits = active & cur.serial & (bitcnt != 3'd7);
  assign take      = launch & hold_v & ~more_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      active <= 1'b0;
      bitcnt <= 3'd0;
    end else if (launch) begin
      if (more_bits) begin
        cur.data <= {cur.data[6:0], 1'b0};
        bitcnt   <= bitcnt + 3'd1;
      end else if (hold_v) begin
        cur    <= hold;
        active <= 1'b1;
        bitcnt <= 3'd0;
      end else begin
        active     <= 1'b0;
        bitcnt     <= 3'd0;
        cur.redund <= cfg_redund;
      end
    end
  end

  always_comb begin
    if (!active)         o_data = 8'd0;
    else if (cur.serial) o_data = {cur.data[7], 7'd0};
    else                 o_data = cur.data;
    o_start = active & cur.start;
    o_err   = active & cur.err;
    o_valid = active ? (~cur.redund | cur.is_data) : ~cur.redund;
  end

  // R9: outputs move only on a launch (inactive edge)
  p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($stable(cur) && $stable(active)));
  // R2: bit index advances only for a serial byte
  p_bitcnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt != 3'd0) |-> (active && cur.serial));
  // R4: start strobe only ever marks a data byte
  p_start_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cur.start) |-> cur.is_data);
endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
  import ts_fmt_pkg::*;
#(
  parameter int DATA_LEN  = 188,
  parameter int PAR_SHORT = 16,
  parameter int PAR_LONG  = 20,
  parameter int HALF_DIV  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_err,
  input  logic       in_par20,
  input  logic       cfg_serial,
  input  logic       cfg_redund,
  input  logic       pol_clk,
  input  logic       pol_start,
  input  logic       pol_valid,
  input  logic       pol_err,
  output logic       ts_clk,
  output logic [7:0] ts_data,
  output logic       ts_start,
  output logic       ts_valid,
  output logic       ts_err
);
  logic     phase, launch, take, hold_v;
  ts_slot_t hold;
  logic     s_start, s_valid, s_err;

  ts_fmt_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .phase(phase), .launch(launch)
  );

  ts_fmt_framer #(
    .DATA_LEN(DATA_LEN), .PAR_SHORT(PAR_SHORT), .PAR_LONG(PAR_LONG)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_err(in_err), .in_par20(in_par20),
    .cfg_serial(cfg_serial), .cfg_redund(cfg_redund), .take(take),
    .hold_v(hold_v), .hold(hold)
  );

  ts_fmt_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cfg_redund(cfg_redund),
    .hold_v(hold_v), .hold(hold), .take(take), .o_data(ts_data),
    .o_start(s_start), .o_valid(s_valid), .o_err(s_err)
  );

  // R8: per-signal polarity
  assign ts_clk   = phase   ^ pol_clk;
  assign ts_start = s_start ^ pol_start;
  assign ts_valid = s_valid ^ pol_valid;
  assign ts_err   = s_err   ^ pol_err;

  // R1: no byte enters while the holding stage is full and not draining
  p_no_overrun_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !take) |-> !in_ready);
endmodule

// File: tb/ts_out_fmt_bench.sv
`timescale 1ns/1ps
module ts_out_fmt_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_err = 0, in_par20 = 0;
  logic [7:0] in_data = 0;
  logic cfg_serial = 0, cfg_redund = 0;
  logic pol_clk = 0, pol_start = 0, pol_valid = 0, pol_err = 0;
  logic in_ready, ts_clk, ts_start, ts_valid, ts_err;
  logic [7:0] ts_data;

  ts_out_fmt u_ts_out_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_err(in_err), .in_par20(in_par20),
    .cfg_serial(cfg_serial), .cfg_redund(cfg_redund), .pol_clk(pol_clk),
    .pol_start(pol_start), .pol_valid(pol_valid), .pol_err(pol_err),
    .ts_clk(ts_clk), .ts_data(ts_data), .ts_start(ts_start),
    .ts_valid(ts_valid), .ts_err(ts_err)
  );

  int checks = 0, fails = 0, bp_seen = 0;
  logic [10:0] expq[$];
  logic [10:0] capq[$];
  bit capturing = 0, prev_ck = 0, have_hi = 0;
  logic [10:0] last_hi;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // Monitor: slot = {data, start, valid, err} decoded to active-high
  always @(negedge clk) begin
    logic ck;
    logic [10:0] cur;
    if (!rst_n) begin
      capturing = 0; prev_ck = 0; have_hi = 0;
    end else begin
      ck  = ts_clk ^ pol_clk;
      cur = {ts_data, ts_start ^ pol_start, ts_valid ^ pol_valid, ts_err ^ pol_err};
      if (ck && !prev_ck) begin
        if (!capturing && cur[2]) capturing = 1;
        if (capturing && capq.size() < expq.size()) capq.push_back(cur);
      end
      if (ck && prev_ck && have_hi)
        check(cur === last_hi, "R9 stable in active half", int'(cur), int'(last_hi));
      if (ck) begin last_hi = cur; have_hi = 1; end
      else have_hi = 0;
      prev_ck = ck;
      if (in_valid && !in_ready) bp_seen++;
    end
  end

  task automatic push(input logic [7:0] d, input bit sop, input bit err, input bit p20);
    in_valid = 1; in_data = d; in_sop = sop; in_err = err; in_par20 = p20;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_pkt(input bit ser, input bit red, input bit p20, input bit err,
                          input int junk, input bit midflip);
    int n;
    logic [7:0] b[];
    n = red ? (p20 ? 208 : 204) : 188;
    b = new[n];
    for (int i = 0; i < n; i++) b[i] = 8'($urandom);
    // expected slots (R2..R7)
    for (int i = 0; i < n; i++) begin
      bit v;
      v = red ? (i < 188) : 1'b1;
      if (ser) begin
        for (int k = 7; k >= 0; k--)
          expq.push_back({b[i][k], 7'd0, (i == 0), v, err});
      end else begin
        expq.push_back({b[i], (i == 0), v, err});
      end
    end
    for (int j = 0; j < junk; j++) push(8'($urandom), 1'b0, 1'b1, ~p20); // R11 junk
    for (int i = 0; i < n; i++) begin
      if (i == 0) begin cfg_serial = ser; cfg_redund = red; end
      if (midflip && i == 100) begin
        cfg_serial = ~ser; cfg_redund = ~red;          // R10 ignored mid-packet
        push(b[i], 1'b1, 1'b1, ~p20);                   // R11 stray sop/err
      end else begin
        push(b[i], (i == 0), (i == 0) ? err : 1'b0, p20);
      end
    end
  endtask

  task automatic seg_begin(input bit pc, input bit ps, input bit pv, input bit pe);
    in_valid = 0; rst_n = 0;
    pol_clk = pc; pol_start = ps; pol_valid = pv; pol_err = pe;
    cfg_serial = 0; cfg_redund = 0;
    expq.delete(); capq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ts_data === 8'd0, "R12 data", int'(ts_data), 0);
    check(ts_start === pol_start && ts_err === pol_err, "R12 strobes inactive",
          int'({ts_start, ts_err}), int'({pol_start, pol_err}));
    check(ts_valid === ~pol_valid, "R12 R5 valid active", int'(ts_valid), int'(~pol_valid));
    check(ts_clk === pol_clk, "R12 R8 clock level", int'(ts_clk), int'(pol_clk));
  endtask

  task automatic seg_end();
    int w = 0;
    while (capq.size() < expq.size() && w < 40000) begin @(negedge clk); w++; end
    check(capq.size() == expq.size(), "R1 slot count", capq.size(), expq.size());
    for (int i = 0; i < capq.size(); i++) begin
      logic [10:0] a, e;
      a = capq[i]; e = expq[i];
      if (a[2] !== e[2])          check(0, "R4 start", int'(a), int'(e));
      else if (a[1] !== e[1])     check(0, "R5 R6 valid", int'(a), int'(e));
      else if (a[0] !== e[0])     check(0, "R7 err", int'(a), int'(e));
      else if (a[10:3] !== e[10:3]) check(0, "R2 R3 R10 data", int'(a), int'(e));
      else                        check(1, "R2 R3 slot", int'(a), int'(e));
    end
    repeat (20) @(negedge clk);
    check((ts_valid ^ pol_valid) === ~cfg_redund, "R5 R6 idle valid",
          int'(ts_valid ^ pol_valid), int'(~cfg_redund));
    check((ts_start ^ pol_start) === 1'b0 && ts_data === 8'd0, "R4 idle",
          int'({ts_start, ts_data}), int'({pol_start, 8'd0}));
  endtask

  bit done = 0;
  initial begin
    void'($urandom(32'h5eed));
    // directed, active-high polarity, parallel
    seg_begin(0, 0, 0, 0);
    send_pkt(0, 0, 0, 0, 0, 0);     // R3 R5
    send_pkt(0, 1, 1, 1, 3, 0);     // R6 (20) R7 R11
    send_pkt(0, 1, 0, 0, 0, 1);     // R6 (16) R10 R11
    seg_end();
    // inverted polarity, serial then parallel
    seg_begin(1, 1, 1, 1);          // R8
    send_pkt(1, 0, 0, 0, 0, 0);     // R2 R4
    send_pkt(1, 1, 0, 1, 2, 1);     // R2 R6 R7 R10
    send_pkt(0, 0, 1, 0, 0, 0);     // R10 boundary switch
    seg_end();
    // random
    seg_begin(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    for (int p = 0; p < 4; p++)
      send_pkt(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               int'($urandom % 3), 1'($urandom));
    seg_end();
    check(bp_seen > 0, "R1 back-pressure seen", bp_seen, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule